// File: doc/BRIEF.md
# DMA channel transfer sequencer

The sequencer is the control engine behind a multi-channel DMA controller. An external arbiter hands it one granted channel at a time. For that channel the sequencer reads the channel's control word and its source and destination end pointers from a control table held in system memory. It then moves one arbitration burst of items, each item being a read followed by a write, and writes the updated control word back to the table. Every memory access goes through a single request/acknowledge port with one access outstanding at a time.

Throughout the pass the sequencer presents a fixed 4-bit state code for the status register. It also drives one-cycle, per-channel update strobes toward the register file. These strobes clear the channel enable, clear the burst-only bit, toggle the primary/alternate select and clear the software request. A global strobe raises the bus-error flag. When the master enable is off, a granted channel waits in a visible stall state. After the final burst, a one-cycle done state pulses a per-channel completion output.

The control word layout is fixed:
- bits [1:0] hold the mode: 0 basic, 1 ping-pong, 2 scatter-gather, 3 treated as basic.
- bits [5:4] hold log2 of the item size in bytes.
- bits [10:8] hold log2 of the burst length in items.
- bits [25:16] hold the remaining item count minus one.
- All other bits are carried through unchanged.

Top module: `dma_seq`

## Requirements
- R1: `state_o` shows only these codes: 0 idle, 1 control read, 2 source end read, 3 destination end read, 4 data read, 5 data write, 6 request-release wait, 7 control write-back, 8 stalled, 9 done. No value from 10 to 15 ever appears.
- R2: A pass runs in this order. First the control word (code 1), then the source end pointer (code 2), then the destination end pointer (code 3). Next come alternating data reads and writes (codes 4 and 5), and last the control write-back (code 7). While `mem_req_o` is high and `mem_ack_i` is low, the request and its address hold steady.
- R3: A primary table entry for channel c sits at base + 16*c, and the alternate entry at base + NCH*16 + 16*c. With the default NCH of 32, that offset is 0x200. Within an entry, offset +0 holds the source end pointer, +4 the destination end pointer and +8 the control word.
- R4: A pass moves min(2^burst, N) items, where N is the count field plus one. The first item sits at end pointer minus (N-1)<<size, and each later item steps by 1<<size. The written-back control word has its count field set to N-1-moved, or to 0 when the transfer is complete. All other bits of the word are unchanged.
- R5: A bus error on any access ends the pass at once and returns to idle. It pulses `err_set_o` and sets `en_clr_o` for that channel only. It pulses no done strobe and issues no further memory access.
- R6: When a basic-mode transfer completes, the state shows 9 for exactly one cycle and then returns to 0. During that cycle `done_o` and `en_clr_o` carry the channel's one-hot bit.
- R7: When a ping-pong or scatter-gather transfer completes, `alt_tgl_o` pulses for the channel and the enable is not cleared.
- R8: If the channel is burst-only and fewer items remain than the burst length, the pass pulses `burst_clr_o` and goes straight back to idle. It reads no pointers, moves no data and writes nothing. If a burst-only transfer completes, `burst_clr_o` pulses at done.
- R9: When a software-requested transfer completes, `swreq_clr_o` pulses for the channel. Software-requested passes skip the wait state.
- R10: After its last data write, a peripheral-requested pass stays in code 6 as long as `periph_req_i` is high. It writes the control word only after `periph_req_i` falls.
- R11: A grant taken while `master_en_i` is low enters code 8 and makes no memory access. The first cycle after the enable returns shows code 1.
- R12: After reset the state is 0, no memory request is raised and every strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_en_i | input | 1 | Controller master enable |
| start_i | input | 1 | Grant strobe, sampled in idle |
| chan_i | input | CH_W | Granted channel number |
| alt_i | input | 1 | Channel uses the alternate table entry |
| burst_only_i | input | 1 | Channel accepts burst requests only |
| sw_req_i | input | 1 | Grant came from a software request |
| periph_req_i | input | 1 | Peripheral request level for the wait state |
| base_i | input | 32 | Control table base address, 1 KiB aligned |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete |
| mem_err_i | input | 1 | Access ended with a bus error (valid with ack) |
| mem_rdata_i | input | 32 | Read data (valid with ack) |
| state_o | output | 4 | Sequencer state code |
| done_o | output | NCH | Per-channel completion pulse |
| en_clr_o | output | NCH | Per-channel enable clear strobe |
| burst_clr_o | output | NCH | Per-channel burst-only clear strobe |
| alt_tgl_o | output | NCH | Per-channel primary/alternate toggle strobe |
| swreq_clr_o | output | NCH | Per-channel software request clear strobe |
| err_set_o | output | 1 | Global bus-error flag set strobe |

## Verification
Passes are run with every mode, with byte, halfword and word sizes, and from both primary and alternate entries. This shows that the entry address and the item stepping come from the right fields. Counts are chosen below, equal to and above the burst length, with and without burst-only and software request. Between them they separate the burst deferral, the partial pass with count write-back, the exact-multiple completion and the short completion. Each case is told apart by the data that lands in memory, the written control word, the recorded state order and which per-channel strobe fires. Directed runs then cover the stall, the request-release wait and a bus error in mid-pass.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE     = 4'h0,
    ST_RD_CTRL  = 4'h1,
    ST_RD_SRC   = 4'h2,
    ST_RD_DST   = 4'h3,
    ST_RD_DATA  = 4'h4,
    ST_WR_DATA  = 4'h5,
    ST_WAIT_REQ = 4'h6,
    ST_WR_CTRL  = 4'h7,
    ST_STALL    = 4'h8,
    ST_DONE     = 4'h9
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_BASIC    = 2'd0,
    MODE_PINGPONG = 2'd1,
    MODE_SCATTER  = 2'd2,
    MODE_RSVD     = 2'd3
  } xfer_mode_e;

  localparam int CNT_W    = 10;
  localparam int CNT_LSB  = 16;
  localparam int ARB_LSB  = 8;
  localparam int SIZE_LSB = 4;
  localparam int MODE_LSB = 0;

  localparam logic [3:0] OFS_SRC  = 4'd0;
  localparam logic [3:0] OFS_DST  = 4'd4;
  localparam logic [3:0] OFS_CTRL = 4'd8;
endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
  import dma_seq_pkg::*;
(
  input  logic [31:0]    ctrl_i,
  input  logic           burst_only_i,
  output logic [CNT_W:0] items_o,
  output logic           fin_o,
  output logic           defer_o,
  output logic           toggle_o,
  output logic [31:0]    span_o,
  output logic [31:0]    step_o,
  output logic [31:0]    ctrl_upd_o
);
  logic [CNT_W-1:0] cnt_m1;
  logic [2:0]       arb_log2;
  logic [1:0]       sz_log2;
  xfer_mode_e       mode;
  logic [CNT_W:0]   total, burst;

  assign cnt_m1   = ctrl_i[CNT_LSB +: CNT_W];
  assign arb_log2 = ctrl_i[ARB_LSB +: 3];
  assign sz_log2  = ctrl_i[SIZE_LSB +: 2];
  assign mode     = xfer_mode_e'(ctrl_i[MODE_LSB +: 2]);

  assign total    = {1'b0, cnt_m1} + 1'b1;
  assign burst    = (CNT_W+1)'(1) << arb_log2;
  assign items_o  = (total < burst) ? total : burst;
  assign fin_o    = (items_o == total);
  assign defer_o  = burst_only_i && (total < burst);
  assign toggle_o = (mode == MODE_PINGPONG) || (mode == MODE_SCATTER);
  assign span_o   = 32'(cnt_m1) << sz_log2;
  assign step_o   = 32'd1 << sz_log2;

  always_comb begin
    ctrl_upd_o = ctrl_i;
    ctrl_upd_o[CNT_LSB +: CNT_W] = fin_o ? '0 : cnt_m1 - items_o[CNT_W-1:0];
  end
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int NCH = 32,
  localparam int CH_W = $clog2(NCH),
  localparam int ALT_OFS = NCH * 16
) (
  input  logic [31:0]   base_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic          alt_i,
  input  logic [3:0]    word_i,
  output logic [31:0]   addr_o
);
  assign addr_o = base_i + (alt_i ? 32'(ALT_OFS) : 32'd0)
                + (32'(chan_i) << 4) + 32'(word_i);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            master_en_i,
  input  logic            start_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            alt_i,
  input  logic            burst_only_i,
  input  logic            sw_req_i,
  input  logic            periph_req_i,
  input  logic [31:0]     base_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [31:0]     mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic            mem_err_i,
  input  logic [31:0]     mem_rdata_i,
  output logic [3:0]      state_o,
  output logic [NCH-1:0]  done_o,
  output logic [NCH-1:0]  en_clr_o,
  output logic [NCH-1:0]  burst_clr_o,
  output logic [NCH-1:0]  alt_tgl_o,
  output logic [NCH-1:0]  swreq_clr_o,
  output logic            err_set_o
);
  seq_state_e      st_q;
  logic [CH_W-1:0] ch_q;
  logic            alt_q, bo_q, sw_q, bclr_q, err_q;
  logic [31:0]     ctrl_q, src_q, dst_q, data_q;
  logic [CNT_W:0]  left_q;

  logic [31:0]     ctrl_cur, span, step, ctrl_upd, entry_addr;
  logic [CNT_W:0]  items;
  logic            fin, defer, toggle;
  logic [3:0]      word_sel;
  logic [NCH-1:0]  ch_oh;

  // decode the word in flight during the control read, the held copy afterwards
  assign ctrl_cur = (st_q == ST_RD_CTRL) ? mem_rdata_i : ctrl_q;

  dma_seq_decode u_decode (
    .ctrl_i      (ctrl_cur),
    .burst_only_i(bo_q),
    .items_o     (items),
    .fin_o       (fin),
    .defer_o     (defer),
    .toggle_o    (toggle),
    .span_o      (span),
    .step_o      (step),
    .ctrl_upd_o  (ctrl_upd)
  );

  always_comb begin
    case (st_q)
      ST_RD_SRC: word_sel = OFS_SRC;
      ST_RD_DST: word_sel = OFS_DST;
      default:   word_sel = OFS_CTRL;
    endcase
  end

  dma_seq_addr #(.NCH(NCH)) u_addr (
    .base_i(base_i),
    .chan_i(ch_q),
    .alt_i (alt_q),
    .word_i(word_sel),
    .addr_o(entry_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      alt_q  <= 1'b0;
      bo_q   <= 1'b0;
      sw_q   <= 1'b0;
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      left_q <= '0;
      bclr_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      bclr_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          ch_q  <= chan_i;
          alt_q <= alt_i;
          bo_q  <= burst_only_i;
          sw_q  <= sw_req_i;
          st_q  <= master_en_i ? ST_RD_CTRL : ST_STALL;
        end
        ST_STALL:    if (master_en_i) st_q <= ST_RD_CTRL;
        ST_WAIT_REQ: if (!periph_req_i) st_q <= ST_WR_CTRL;
        ST_DONE:     st_q <= ST_IDLE;
        default: if (mem_ack_i) begin
          if (mem_err_i) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
          end else begin
            case (st_q)
              ST_RD_CTRL: begin
                ctrl_q <= mem_rdata_i;
                left_q <= items;
                if (defer) begin
                  bclr_q <= 1'b1;
                  st_q   <= ST_IDLE;
                end else begin
                  st_q <= ST_RD_SRC;
                end
              end
              ST_RD_SRC: begin
                src_q <= mem_rdata_i - span;
                st_q  <= ST_RD_DST;
              end
              ST_RD_DST: begin
                dst_q <= mem_rdata_i - span;
                st_q  <= ST_RD_DATA;
              end
              ST_RD_DATA: begin
                data_q <= mem_rdata_i;
                st_q   <= ST_WR_DATA;
              end
              ST_WR_DATA: begin
                src_q  <= src_q + step;
                dst_q  <= dst_q + step;
                left_q <= left_q - 1'b1;
                if (left_q == (CNT_W+1)'(1)) st_q <= sw_q ? ST_WR_CTRL : ST_WAIT_REQ;
                else                         st_q <= ST_RD_DATA;
              end
              ST_WR_CTRL: st_q <= fin ? ST_DONE : ST_IDLE;
              default:    st_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    case (st_q)
      ST_RD_CTRL, ST_RD_SRC, ST_RD_DST, ST_RD_DATA: mem_req_o = 1'b1;
      ST_WR_DATA, ST_WR_CTRL: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_addr_o  = (st_q == ST_RD_DATA) ? src_q :
                       (st_q == ST_WR_DATA) ? dst_q : entry_addr;
  assign mem_wdata_o = (st_q == ST_WR_CTRL) ? ctrl_upd : data_q;

  assign ch_oh       = NCH'(1) << ch_q;
  assign state_o     = st_q;
  assign done_o      = (st_q == ST_DONE) ? ch_oh : '0;
  assign en_clr_o    = (err_q || (st_q == ST_DONE && !toggle)) ? ch_oh : '0;
  assign alt_tgl_o   = (st_q == ST_DONE && toggle) ? ch_oh : '0;
  assign burst_clr_o = (bclr_q || (st_q == ST_DONE && bo_q)) ? ch_oh : '0;
  assign swreq_clr_o = (st_q == ST_DONE && sw_q) ? ch_oh : '0;
  assign err_set_o   = err_q;

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 4'd9); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R2
  AST_SRC_AFTER_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RD_SRC |-> $past(st_q) == ST_RD_CTRL || $past(st_q) == ST_RD_SRC); // R2
  AST_ERR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && mem_err_i |=> err_set_o && !mem_req_o && done_o == '0); // R5
  AST_ONE_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_clr_o)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DONE |=> st_q == ST_IDLE); // R6
  AST_DEFER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RD_CTRL && mem_ack_i && !mem_err_i && defer |=> burst_clr_o != '0 && st_q == ST_IDLE); // R8
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT_REQ && periph_req_i |=> st_q == ST_WAIT_REQ); // R10
  AST_STALL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_STALL && master_en_i |=> st_q == ST_RD_CTRL); // R11
endmodule

// File: tb/dma_seq_tb.sv
`timescale 1ns/1ps
module dma_seq_tb;
  localparam int NCH = 32;
  localparam logic [31:0] BASE = 32'h2000_0000;

  typedef struct packed {
    logic [4:0]  ch;
    logic        alt;
    logic [1:0]  mode;
    logic [1:0]  sz;
    logic [2:0]  arb;
    logic [9:0]  cm1;
    logic        bo;
    logic        sw;
    logic [10:0] items;
    logic        fin;
    logic        enclr;
    logic        tgl;
    logic        bclr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  1'b0, 2'd0, 2'd2, 3'd2, 10'd2, 1'b1, 1'b1, 11'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{5'd5,  1'b0, 2'd0, 2'd0, 3'd1, 10'd4, 1'b0, 1'b0, 11'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd7,  1'b1, 2'd1, 2'd1, 3'd3, 10'd7, 1'b1, 1'b0, 11'd8, 1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd31, 1'b0, 2'd2, 2'd2, 3'd0, 10'd0, 1'b0, 1'b1, 11'd1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd0,  1'b1, 2'd0, 2'd2, 3'd2, 10'd7, 1'b1, 1'b0, 11'd4, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd9,  1'b0, 2'd0, 2'd2, 3'd2, 10'd2, 1'b0, 1'b1, 11'd3, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_en_i = 1'b1, start_i = 1'b0, alt_i = 1'b0, burst_only_i = 1'b0;
  logic sw_req_i = 1'b0, periph_req_i = 1'b0;
  logic [4:0] chan_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic [3:0] state_o;
  logic [NCH-1:0] done_o, en_clr_o, burst_clr_o, alt_tgl_o, swreq_clr_o;
  logic err_set_o;

  always #10 clk = ~clk;

  dma_seq #(.NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_en_i(master_en_i), .start_i(start_i),
    .chan_i(chan_i), .alt_i(alt_i), .burst_only_i(burst_only_i), .sw_req_i(sw_req_i),
    .periph_req_i(periph_req_i), .base_i(BASE), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_err_i(mem_err_i), .mem_rdata_i(mem_rdata_i), .state_o(state_o), .done_o(done_o),
    .en_clr_o(en_clr_o), .burst_clr_o(burst_clr_o), .alt_tgl_o(alt_tgl_o),
    .swreq_clr_o(swreq_clr_o), .err_set_o(err_set_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [logic [31:0]];
  logic [NCH-1:0] acc_done, acc_en, acc_bclr, acc_tgl, acc_sw;
  logic acc_err, bad_code, err_en, post_err;
  logic [31:0] err_addr;
  int post_acc, w6, tn;
  logic [3:0] last_st;
  logic [3:0] trace [64];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    acc_done = '0; acc_en = '0; acc_bclr = '0; acc_tgl = '0; acc_sw = '0;
    acc_err = 1'b0; post_err = 1'b0; post_acc = 0; w6 = 0; tn = 0; last_st = 4'd0;
  endtask

  // memory responder and strobe monitor
  initial begin
    err_en = 1'b0; err_addr = '0; bad_code = 1'b0;
    clr_mon();
    forever begin
      @(negedge clk);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        mem_err_i = 1'b0;
      end else if (mem_req_o) begin
        mem_ack_i = 1'b1;
        if (post_err) post_acc++;
        if (err_en && mem_addr_o == err_addr) begin
          mem_err_i = 1'b1;
          post_err  = 1'b1;
        end else if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
        else mem_rdata_i = rd(mem_addr_o);
      end
      acc_done |= done_o; acc_en |= en_clr_o; acc_bclr |= burst_clr_o;
      acc_tgl |= alt_tgl_o; acc_sw |= swreq_clr_o; acc_err |= err_set_o;
      if (state_o > 4'd9) bad_code = 1'b1;
      if (state_o != last_st) begin
        if (tn < 64) trace[tn] = state_o;
        tn++;
        last_st = state_o;
      end
      if (state_o == 4'd6) begin
        w6++;
        if (w6 == 3) periph_req_i = 1'b0;
      end
    end
  end

  function automatic logic [31:0] mk_ctrl(input logic [1:0] m, input logic [1:0] s,
                                          input logic [2:0] a, input logic [9:0] c);
    return {6'd0, c, 5'd0, a, 2'd0, s, 2'd0, m};
  endfunction

  task automatic grant(input logic [4:0] ch, input logic alt, input logic bo, input logic sw);
    @(negedge clk);
    chan_i = ch; alt_i = alt; burst_only_i = bo; sw_req_i = sw; periph_req_i = !sw;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (state_o != 4'd0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input int k, input logic [4:0] ch, input logic alt, input logic [31:0] ctrl,
                       input logic [1:0] sz, input logic [9:0] cm1,
                       output logic [31:0] ent, output logic [31:0] s0, output logic [31:0] d0);
    ent = BASE + (alt ? 32'h200 : 32'h0) + 32'(ch) * 16;
    s0 = 32'h1000_0000 + 32'(k) * 32'h1000;
    d0 = 32'h3000_0000 + 32'(k) * 32'h1000;
    mem[ent]     = s0 + (32'(cm1) << sz);
    mem[ent + 4] = d0 + (32'(cm1) << sz);
    mem[ent + 8] = ctrl;
    for (int i = 0; i <= int'(cm1); i++) begin
      mem[s0 + (32'(i) << sz)] = 32'hA500_0000 | (32'(k) << 8) | 32'(i);
      mem[d0 + (32'(i) << sz)] = 32'hDEAD_0000 | 32'(i);
    end
  endtask

  task automatic run_vec(input int k, input vec_t v);
    logic [31:0] ent, s0, d0, ctrl, exp_ctrl, oh;
    ctrl = mk_ctrl(v.mode, v.sz, v.arb, v.cm1);
    setup(k, v.ch, v.alt, ctrl, v.sz, v.cm1, ent, s0, d0);
    exp_ctrl = ctrl;
    if (v.items != 0) exp_ctrl[25:16] = v.fin ? 10'd0 : v.cm1 - v.items[9:0];
    oh = 32'd1 << v.ch;
    clr_mon();
    grant(v.ch, v.alt, v.bo, v.sw);
    wait_idle();
    for (int i = 0; i < int'(v.items); i++)
      chk("R4", $sformatf("vec %0d item %0d moved", k, i), rd(d0 + (32'(i) << v.sz)),
          32'hA500_0000 | (32'(k) << 8) | 32'(i));
    if (int'(v.items) <= int'(v.cm1))
      chk("R4", $sformatf("vec %0d item past burst untouched", k),
          rd(d0 + (32'(v.items) << v.sz)), 32'hDEAD_0000 | 32'(v.items));
    chk("R3", $sformatf("vec %0d control word at entry", k), rd(ent + 8), exp_ctrl);
    chk("R6", $sformatf("vec %0d done strobe", k), acc_done, v.fin ? oh : 32'd0);
    chk("R6", $sformatf("vec %0d enable clear", k), acc_en, v.enclr ? oh : 32'd0);
    chk("R7", $sformatf("vec %0d alternate toggle", k), acc_tgl, v.tgl ? oh : 32'd0);
    chk("R8", $sformatf("vec %0d burst-only clear", k), acc_bclr, v.bclr ? oh : 32'd0);
    chk("R9", $sformatf("vec %0d software request clear", k), acc_sw, (v.sw && v.fin) ? oh : 32'd0);
    chk("R2", $sformatf("vec %0d first code", k), 32'(trace[0]), 32'd1);
    if (v.items == 0) begin
      chk("R8", $sformatf("vec %0d deferred pass trace length", k), 32'(tn), 32'd2);
    end else begin
      chk("R2", $sformatf("vec %0d pointer/data order", k),
          {16'd0, trace[1], trace[2], trace[3], trace[4]}, 32'h2345);
      chk("R2", $sformatf("vec %0d write-back before end", k),
          32'(trace[tn - (v.fin ? 3 : 2)]), 32'd7);
      if (v.fin) chk("R6", $sformatf("vec %0d done code", k), 32'(trace[tn - 2]), 32'd9);
      chk("R10", $sformatf("vec %0d wait cycles", k), 32'(w6), v.sw ? 32'd0 : 32'd3);
    end
  endtask

  initial begin
    logic [31:0] ent, s0, d0;
    repeat (3) @(negedge clk);
    chk("R12", "reset state", 32'(state_o), 32'd0);
    chk("R12", "reset request", 32'(mem_req_o), 32'd0);
    chk("R12", "reset strobes", done_o | en_clr_o | burst_clr_o | alt_tgl_o | swreq_clr_o,
        32'd0);
    chk("R12", "reset error strobe", 32'(err_set_o), 32'd0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(k, VECS[k]);

    // R11: stall until master enable returns
    setup(7, 5'd2, 1'b0, mk_ctrl(2'd0, 2'd2, 3'd0, 10'd0), 2'd2, 10'd0, ent, s0, d0);
    clr_mon();
    master_en_i = 1'b0;
    grant(5'd2, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      chk("R11", "stalled code", 32'(state_o), 32'd8);
      chk("R11", "no access while stalled", 32'(mem_req_o), 32'd0);
      @(negedge clk);
    end
    master_en_i = 1'b1;
    @(negedge clk);
    chk("R11", "resume to control read", 32'(state_o), 32'd1);
    wait_idle();
    chk("R11", "stalled pass completes", rd(d0), 32'hA500_0700);

    // R5: bus error on the first data read
    setup(8, 5'd4, 1'b0, mk_ctrl(2'd0, 2'd2, 3'd2, 10'd3), 2'd2, 10'd3, ent, s0, d0);
    clr_mon();
    err_addr = s0;
    err_en = 1'b1;
    grant(5'd4, 1'b0, 1'b0, 1'b1);
    wait_idle();
    err_en = 1'b0;
    chk("R5", "error flag strobe", 32'(acc_err), 32'd1);
    chk("R5", "only faulting channel disabled", acc_en, 32'h10);
    chk("R5", "no done on error", acc_done, 32'd0);
    chk("R5", "no access after error", 32'(post_acc), 32'd0);
    chk("R5", "destination untouched", rd(d0), 32'hDEAD_0000);
    chk("R5", "control word not rewritten", rd(ent + 8), mk_ctrl(2'd0, 2'd2, 3'd2, 10'd3));

    chk("R1", "no undefined state code seen", 32'(bad_code), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected idle");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule